// File: doc/BRIEF.md
# Stereo Channel Mixer with Master Gain

This block takes the instantaneous amplitudes of four sound channels and forms two unsigned mix values, one for the left side and one for the right side. A routing byte selects, for each channel, whether it feeds the right sum, the left sum, both or neither. A gain byte carries one 3-bit level per side. Each side's sum is multiplied by that level plus one.

The result is captured into output registers only on a clock edge where the sample strobe is high. Between strobes the outputs hold, so register writes made between strobes take effect at the next strobe. While the power input is low, both outputs are cleared and stay at zero. Later stages handle conversion, filtering and bias.

Top module: `stereo_mixer`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released until the first capture, leftOut and rightOut are both zero.
- R2: Channel n (amplitude on chanAmp[4n+3:4n]) is added to the right sum when routeReg bit n is 1 and is left out of it when the bit is 0.
- R3: Channel n is added to the left sum when routeReg bit n+4 is 1 and is left out of it when the bit is 0. A channel may feed both sides, one side or neither.
- R4: rightOut equals the right sum multiplied by (gainReg[2:0] + 1).
- R5: leftOut equals the left sum multiplied by (gainReg[6:4] + 1).
- R6: gainReg bits 7 and 3 have no effect on either output.
- R7: On a rising clock edge with powerOn high and sampleStrobe high, the outputs load the values computed from the inputs present at that edge. On an edge with powerOn high and sampleStrobe low, the outputs keep their previous values, whatever the other inputs do.
- R8: On any rising clock edge with powerOn low, both outputs become zero, whatever sampleStrobe is. They stay zero until a strobe arrives with power high.
- R9: Each output is 9 bits wide and reaches 480 (all four channels at 15, level 7) without wrapping. No output value ever exceeds 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOn | input | 1 | High enables mixing; low clears both outputs |
| sampleStrobe | input | 1 | High for one cycle to capture a new sample |
| chanAmp | input | 16 | Four 4-bit channel amplitudes, channel n at bits 4n+3:4n |
| routeReg | input | 8 | Bit n routes channel n right; bit n+4 routes it left |
| gainReg | input | 8 | Bits 6:4 left level, bits 2:0 right level; bits 7 and 3 unused here |
| leftOut | output | 9 | Registered left mix value |
| rightOut | output | 9 | Registered right mix value |

## Verification
The assertions assume that every input is synchronous to clk and settled at the rising edge. They also assume that reset is held low for at least one edge before any check starts. The bench satisfies this by changing every input only on the falling edge, including the strobe and power, and by keeping reset asserted for several cycles. The hold checks change the amplitudes, routing and gain while the strobe is low. This shows that the assertion on stable outputs only relies on the strobe and power inputs, and not on the data inputs being quiet.

// File: rtl/mix_pkg.sv
package mix_pkg;
  // Control strobes handed from the controller to the datapath
  typedef struct packed {
    logic load;   // capture freshly mixed values
    logic clear;  // force both sides to zero
  } mixCtrl_t;
endpackage

// File: rtl/mix_ctrl.sv
module mix_ctrl
  import mix_pkg::*;
(
  input  logic     powerOn,
  input  logic     sampleStrobe,
  output mixCtrl_t ctrl
);
  // Power-down wins over a pending strobe
  always_comb begin
    ctrl.clear = !powerOn;
    ctrl.load  = powerOn && sampleStrobe;
  end
endmodule

// File: rtl/mix_datapath.sv
module mix_datapath
  import mix_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AMP_W  = 4,
  parameter int LVL_W  = 3,
  parameter int OUT_W  = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mixCtrl_t                  ctrl,
  input  logic [NUM_CH*AMP_W-1:0]   chanAmp,
  input  logic [2*NUM_CH-1:0]       routeReg,
  input  logic [2*(LVL_W+1)-1:0]    gainReg,
  output logic [OUT_W-1:0]          leftOut,
  output logic [OUT_W-1:0]          rightOut
);
  localparam int SUM_W   = AMP_W + $clog2(NUM_CH);
  localparam int FIELD_W = LVL_W + 1;   // level field plus one unused bit
  localparam int NUM_SIDE = 2;          // index 0 = right, 1 = left

  logic [OUT_W-1:0] sideReg [NUM_SIDE];

  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
    logic [SUM_W-1:0] routedSum;
    logic [LVL_W:0]   sideGain;
    logic [OUT_W-1:0] scaled;

    always_comb begin
      routedSum = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (routeReg[s*NUM_CH + ch])
          routedSum = routedSum + SUM_W'(chanAmp[ch*AMP_W +: AMP_W]);
      end
    end

    assign sideGain = {1'b0, gainReg[s*FIELD_W +: LVL_W]} + (LVL_W+1)'(1);
    assign scaled   = OUT_W'(routedSum) * OUT_W'(sideGain);

    always_ff @(posedge clk) begin
      if (!rstN || ctrl.clear) sideReg[s] <= '0;
      else if (ctrl.load)      sideReg[s] <= scaled;
    end
  end

  assign rightOut = sideReg[0];
  assign leftOut  = sideReg[1];
endmodule

// File: rtl/stereo_mixer.sv
module stereo_mixer
  import mix_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AMP_W  = 4,
  parameter int LVL_W  = 3,
  localparam int OUT_W = AMP_W + $clog2(NUM_CH) + LVL_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    powerOn,
  input  logic                    sampleStrobe,
  input  logic [NUM_CH*AMP_W-1:0] chanAmp,
  input  logic [2*NUM_CH-1:0]     routeReg,
  input  logic [2*(LVL_W+1)-1:0]  gainReg,
  output logic [OUT_W-1:0]        leftOut,
  output logic [OUT_W-1:0]        rightOut
);
  mixCtrl_t ctrl;

  mix_ctrl u_ctrl (
    .powerOn      (powerOn),
    .sampleStrobe (sampleStrobe),
    .ctrl         (ctrl)
  );

  mix_datapath #(
    .NUM_CH (NUM_CH),
    .AMP_W  (AMP_W),
    .LVL_W  (LVL_W),
    .OUT_W  (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .chanAmp  (chanAmp),
    .routeReg (routeReg),
    .gainReg  (gainReg),
    .leftOut  (leftOut),
    .rightOut (rightOut)
  );
endmodule

// File: rtl/stereo_mixer_chk.sv
module stereo_mixer_chk #(
  parameter int NUM_CH = 4,
  parameter int AMP_W  = 4,
  parameter int LVL_W  = 3,
  parameter int OUT_W  = 9
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    powerOn,
  input logic                    sampleStrobe,
  input logic [NUM_CH*AMP_W-1:0] chanAmp,
  input logic [2*NUM_CH-1:0]     routeReg,
  input logic [2*(LVL_W+1)-1:0]  gainReg,
  input logic [OUT_W-1:0]        leftOut,
  input logic [OUT_W-1:0]        rightOut
);
  localparam int MAX_OUT = NUM_CH * ((1 << AMP_W) - 1) * (1 << LVL_W);

  assert_power_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> (leftOut == '0 && rightOut == '0));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rstN)
    (powerOn && !sampleStrobe) |=> ($stable(leftOut) && $stable(rightOut)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (32'(leftOut) <= MAX_OUT && 32'(rightOut) <= MAX_OUT));

  assert_right_unrouted_R2: assert property (@(posedge clk) disable iff (!rstN)
    (powerOn && sampleStrobe && routeReg[NUM_CH-1:0] == '0) |=> rightOut == '0);

  assert_left_unrouted_R3: assert property (@(posedge clk) disable iff (!rstN)
    (powerOn && sampleStrobe && routeReg[2*NUM_CH-1:NUM_CH] == '0) |=> leftOut == '0);
endmodule

bind stereo_mixer stereo_mixer_chk #(
  .NUM_CH (NUM_CH),
  .AMP_W  (AMP_W),
  .LVL_W  (LVL_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .powerOn      (powerOn),
  .sampleStrobe (sampleStrobe),
  .chanAmp      (chanAmp),
  .routeReg     (routeReg),
  .gainReg      (gainReg),
  .leftOut      (leftOut),
  .rightOut     (rightOut)
);

// File: tb/stereo_mixer_tb.sv
module stereo_mixer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerOn = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] chanAmp = '0;
  logic [7:0]  routeReg = '0;
  logic [7:0]  gainReg = '0;
  logic [8:0]  leftOut, rightOut;

  always #5 clk = ~clk;

  stereo_mixer u_dut (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .sampleStrobe(sampleStrobe),
    .chanAmp(chanAmp), .routeReg(routeReg), .gainReg(gainReg),
    .leftOut(leftOut), .rightOut(rightOut)
  );

  typedef struct {
    int    expL;
    int    expR;
    string tag;
  } item_t;

  item_t scoreQ[$];
  int    total = 0;
  int    bad = 0;
  logic  expectNow = 1'b0;
  int    lastL = 0;
  int    lastR = 0;

  function automatic int sideSum(logic [15:0] a, logic [7:0] r, int side);
    int acc = 0;
    for (int ch = 0; ch < 4; ch++)
      if (r[side*4 + ch]) acc += int'(a[ch*4 +: 4]);
    return acc;
  endfunction

  // Driver: sets inputs for one edge and queues the expected outputs
  task automatic drive(input logic [15:0] a, input logic [7:0] r, input logic [7:0] g,
                       input logic pw, input logic stb, input string tag);
    item_t it;
    @(negedge clk);
    chanAmp = a; routeReg = r; gainReg = g; powerOn = pw; sampleStrobe = stb;
    if (!pw) begin
      lastL = 0; lastR = 0;
    end else if (stb) begin
      lastR = sideSum(a, r, 0) * (int'(g[2:0]) + 1);
      lastL = sideSum(a, r, 1) * (int'(g[6:4]) + 1);
    end
    it.expL = lastL; it.expR = lastR; it.tag = tag;
    scoreQ.push_back(it);
    expectNow = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    sampleStrobe = 1'b0;
    expectNow = 1'b0;
  endtask

  // Monitor: after each edge that carries an expectation, compare at the falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (expectNow) begin
        item_t it;
        @(negedge clk);
        it = scoreQ.pop_front();
        total++;
        if (int'(leftOut) != it.expL || int'(rightOut) != it.expR) begin
          bad++;
          $display("FAIL %s: left=%0d right=%0d expected left=%0d right=%0d",
                   it.tag, leftOut, rightOut, it.expL, it.expR);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    powerOn = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (leftOut != 0 || rightOut != 0) begin
      bad++;
      $display("FAIL R1: left=%0d right=%0d expected left=0 right=0", leftOut, rightOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (leftOut != 0 || rightOut != 0) begin
      bad++;
      $display("FAIL R1 after release: left=%0d right=%0d expected 0/0", leftOut, rightOut);
    end

    drive(16'hFFFF, 8'hFF, 8'h77, 1'b1, 1'b1, "R9 full scale 480");
    drive(16'h8421, 8'h0F, 8'h00, 1'b1, 1'b1, "R2 right only unity gain");
    drive(16'h8421, 8'hF0, 8'h30, 1'b1, 1'b1, "R3 R5 left only gain 4");
    drive(16'h8421, 8'h5A, 8'h25, 1'b1, 1'b1, "R2 R3 R4 mixed routing");
    drive(16'h8421, 8'h5A, 8'hA5, 1'b1, 1'b1, "R6 unused gain bits 7 and 3");
    drive(16'h8421, 8'h5A, 8'h8D, 1'b1, 1'b1, "R6 bits 7 and 3 with right 5");
    drive(16'hFFFF, 8'hFF, 8'h77, 1'b1, 1'b0, "R7 hold without strobe");
    drive(16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, "R7 hold second cycle");
    drive(16'h3C96, 8'h33, 8'h61, 1'b1, 1'b1, "R7 capture at strobe");
    drive(16'hFFFF, 8'h00, 8'h77, 1'b1, 1'b1, "R2 R3 routed nowhere");
    drive(16'hFFFF, 8'h11, 8'h07, 1'b1, 1'b1, "R3 R4 channel 0 both sides");
    drive(16'hFFFF, 8'hFF, 8'h77, 1'b0, 1'b0, "R8 power low no strobe");
    drive(16'hFFFF, 8'hFF, 8'h77, 1'b0, 1'b1, "R8 power low with strobe");
    drive(16'hFFFF, 8'hFF, 8'h77, 1'b1, 1'b0, "R8 stays zero until strobe");
    drive(16'hF000, 8'h88, 8'h70, 1'b1, 1'b1, "R5 R9 channel 3 left gain 8");
    drive(16'h0F00, 8'h44, 8'h07, 1'b1, 1'b1, "R4 channel 2 right gain 8");
    idle();
    repeat (3) @(negedge clk);

    total++;
    if (scoreQ.size() != 0) begin
      bad++;
      $display("FAIL R7: %0d items unchecked, expected 0", scoreQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule